// File: doc/BRIEF.md
# Boot Remap Controller with Slave Window Decode

This block sits on the register bus of an AHB-based system and holds one 32-bit configuration word for each of up to 32 slave windows. Bits [31:20] of a word give the window base in megabyte units and bits [19:16] give a size code k, meaning a window of 2^k megabytes. From these words the block drives the effective base and size of every window. A combinational decoder turns any bus address into a one-hot slave select.

One slave is the boot ROM and another is the working RAM. Software sets the remap bit in the control register once. From then on the RAM sits at the old ROM base and the ROM moves up, just past the end of the RAM window. Remap cannot be undone except by reset. A register read of the ROM or RAM slot returns the base that is currently in effect. Illegal accesses produce a one-cycle error pulse.

Top module: `boot_remap_ctrl`

## Requirements
- R1: After reset, the remap state is off, acc_rdata and acc_err are 0, and slave word n holds base n*BASE_STEP (12 bits, modulo 4096) in [31:20], DFLT_SIZE in [19:16] and zero in [15:0].
- R2: A full access (acc_be = 4'hF, acc_addr[1:0] = 0) at byte offset 4*n, for n below NUM_SLV, writes or reads slave word n. For slaves other than the ROM and RAM slots, the read returns the stored word unchanged.
- R3: Offset 0x8C always reads 0x00010301, and writes to it are ignored. Offsets 0x80 and 0x84 accept writes, read as zero, and raise no error.
- R4: A control write (offset 0x88) with bit 0 set, while remap is off, turns remap on. The RAM base becomes bits [31:20] of the ROM slot word. The ROM base becomes that value plus 2^k, where k is bits [19:16] of the RAM slot word and the sum is modulo 4096.
- R5: Remap is sticky. A control write with bit 0 clear while remap is on raises acc_err for one cycle and leaves remap on. A control read returns 1 in bit 0 while remap is on, and every other bit reads 0.
- R6: A read of the ROM slot or the RAM slot returns {effective base, stored size field, 16'h0000}.
- R7: After remap, a write to the ROM or RAM slot updates the stored word, and with it the size shown on readback. The effective base latched at remap does not change.
- R8: An access to an undefined offset (at or above 0x90, or between NUM_SLV*4 and 0x7F), a misaligned access, or a partial-strobe access raises acc_err for one cycle. A read of this kind returns 0. A write of this kind changes no state.
- R9: A window hits when its size code is non-zero and the bits of bus_addr[31:20] above the lowest k match its base. With k of 12 or more, every address matches. slave_sel is one-hot on the lowest-numbered hitting slave, and is zero when no window hits.
- R10: acc_rdata and acc_err are registered and appear in the cycle after the access. win_base, win_size and remap_active reflect a write from the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe (ignored when acc_wr is high) |
| acc_addr | input | 12 | Register byte offset |
| acc_be | input | 4 | Byte enables; only 4'hF is a valid access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| acc_err | output | 1 | One-cycle error pulse |
| remap_active | output | 1 | Remap state |
| win_base | output | NUM_SLV*12 | Effective base of each window, slave n at [n*12 +: 12] |
| win_size | output | NUM_SLV*4 | Size code of each window, slave n at [n*4 +: 4] |
| bus_addr | input | 32 | Address to decode |
| slave_sel | output | NUM_SLV | One-hot slave select |

## Verification
The bench uses the default parameters: 32 slaves, ROM in slot 4, RAM in slot 6, BASE_STEP 16 and DFLT_SIZE 1. This places every window on its own 16-megabyte boundary and gives it a 2-megabyte span. With a full set of 32 slots, the last slave word sits at 0x7C, directly below the priority register. The bench can therefore exercise both edges of the slave range and the remap arithmetic with a non-default RAM size. It also builds overlapping and match-all windows by rewriting slot words, which brings the decoder's lowest-index priority within reach.

// File: rtl/remap_pkg.sv
package remap_pkg;

    localparam int REG_AW = 12;

    localparam logic [REG_AW-1:0] OFS_PRIO = 12'h080;
    localparam logic [REG_AW-1:0] OFS_IDLE = 12'h084;
    localparam logic [REG_AW-1:0] OFS_CTRL = 12'h088;
    localparam logic [REG_AW-1:0] OFS_REV  = 12'h08C;

    localparam logic [31:0] REV_WORD = 32'h0001_0301;

    // Mask applied to address bits [31:20] for a window of 2^k megabytes.
    function automatic logic [11:0] win_mask(input logic [3:0] k);
        if (k >= 4'd12) return 12'h000;
        return ~((12'd1 << k) - 12'd1);
    endfunction

endpackage

// File: rtl/remap_regfile.sv
module remap_regfile
    import remap_pkg::*;
#(
    parameter int NUM_SLV   = 32,   // at most 32: slot words must stay below 0x80
    parameter int ROM_IDX   = 4,
    parameter int RAM_IDX   = 6,
    parameter int BASE_STEP = 16,
    parameter int DFLT_SIZE = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_wr,
    input  logic                    acc_rd,
    input  logic [REG_AW-1:0]       acc_addr,
    input  logic [3:0]              acc_be,
    input  logic [31:0]             acc_wdata,
    output logic [31:0]             acc_rdata,
    output logic                    acc_err,
    output logic                    remap_active,
    output logic [NUM_SLV*12-1:0]   win_base,
    output logic [NUM_SLV*4-1:0]    win_size
);

    localparam int IDX_W    = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1;
    localparam int SLV_SPAN = NUM_SLV * 4;

    typedef struct packed {
        logic [NUM_SLV-1:0][31:0] slv;
        logic                     remap;
        logic [11:0]              ram_base;
        logic [11:0]              rom_base;
        logic [31:0]              rdata;
        logic                     err;
    } state_t;

    state_t st_d, st_q;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int i = 0; i < NUM_SLV; i++) begin
            s.slv[i] = {12'(i * BASE_STEP), 4'(DFLT_SIZE), 16'h0000};
        end
        return s;
    endfunction

    // Effective bases: ROM and RAM follow the latched values once remapped.
    logic [NUM_SLV-1:0][11:0] base_eff;
    logic [NUM_SLV-1:0][3:0]  size_eff;

    for (genvar g = 0; g < NUM_SLV; g++) begin : g_win
        if (g == ROM_IDX) begin : g_rom
            assign base_eff[g] = st_q.remap ? st_q.rom_base : st_q.slv[g][31:20];
        end else if (g == RAM_IDX) begin : g_ram
            assign base_eff[g] = st_q.remap ? st_q.ram_base : st_q.slv[g][31:20];
        end else begin : g_plain
            assign base_eff[g] = st_q.slv[g][31:20];
        end
        assign size_eff[g] = st_q.slv[g][19:16];
    end

    logic             full_acc, is_slv, is_prio, is_idle, is_ctrl, is_rev, known;
    logic [IDX_W-1:0] slot;
    logic [31:0]      rd_word;

    always_comb begin
        full_acc = (acc_be == 4'hF) && (acc_addr[1:0] == 2'b00);
        is_slv   = full_acc && (acc_addr < REG_AW'(SLV_SPAN));
        is_prio  = full_acc && (acc_addr == OFS_PRIO);
        is_idle  = full_acc && (acc_addr == OFS_IDLE);
        is_ctrl  = full_acc && (acc_addr == OFS_CTRL);
        is_rev   = full_acc && (acc_addr == OFS_REV);
        known    = is_slv || is_prio || is_idle || is_ctrl || is_rev;
        slot     = acc_addr[IDX_W+1:2];

        rd_word = 32'h0;
        if (is_slv) begin
            if ((int'(slot) == ROM_IDX) || (int'(slot) == RAM_IDX))
                rd_word = {base_eff[slot], st_q.slv[slot][19:16], 16'h0000};
            else
                rd_word = st_q.slv[slot];
        end else if (is_ctrl) begin
            rd_word = {31'h0, st_q.remap};
        end else if (is_rev) begin
            rd_word = REV_WORD;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (acc_wr) begin
            if (!known) begin
                st_d.err = 1'b1;
            end else if (is_slv) begin
                st_d.slv[slot] = acc_wdata;
            end else if (is_ctrl) begin
                if (acc_wdata[0] && !st_q.remap) begin
                    st_d.remap    = 1'b1;
                    st_d.ram_base = st_q.slv[ROM_IDX][31:20];
                    st_d.rom_base = st_q.slv[ROM_IDX][31:20]
                                  + (12'd1 << st_q.slv[RAM_IDX][19:16]);
                end else if (!acc_wdata[0] && st_q.remap) begin
                    st_d.err = 1'b1;
                end
            end
        end else if (acc_rd) begin
            st_d.rdata = rd_word;
            st_d.err   = !known;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    assign acc_rdata    = st_q.rdata;
    assign acc_err      = st_q.err;
    assign remap_active = st_q.remap;
    assign win_base     = base_eff;
    assign win_size     = size_eff;

    AST_REMAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.remap |=> st_q.remap); // R5

    AST_ERR_KEEPS_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $stable(st_q.remap)); // R8

    AST_RAM_FROM_ROM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.remap) |-> st_q.ram_base == $past(st_q.slv[ROM_IDX][31:20])); // R4

    AST_ROM_ABOVE_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.remap) |->
            st_q.rom_base == 12'(st_q.ram_base + (12'd1 << $past(st_q.slv[RAM_IDX][19:16])))); // R4

    AST_REV_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !acc_wr && acc_be == 4'hF && acc_addr == OFS_REV) |=> acc_rdata == REV_WORD); // R3

endmodule

// File: rtl/remap_decoder.sv
module remap_decoder
    import remap_pkg::*;
#(
    parameter int NUM_SLV = 32
) (
    input  logic [NUM_SLV*12-1:0] win_base,
    input  logic [NUM_SLV*4-1:0]  win_size,
    input  logic [31:0]           bus_addr,
    output logic [NUM_SLV-1:0]    slave_sel
);

    logic [NUM_SLV-1:0] hit;

    for (genvar g = 0; g < NUM_SLV; g++) begin : g_cmp
        logic [11:0] msk;
        assign msk    = win_mask(win_size[g*4 +: 4]);
        assign hit[g] = (win_size[g*4 +: 4] != 4'd0)
                     && ((bus_addr[31:20] & msk) == (win_base[g*12 +: 12] & msk));
    end

    always_comb begin
        logic found;
        found     = 1'b0;
        slave_sel = '0;
        for (int i = 0; i < NUM_SLV; i++) begin
            if (hit[i] && !found) begin
                slave_sel[i] = 1'b1;
                found        = 1'b1;
            end
        end
    end

endmodule

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl
    import remap_pkg::*;
#(
    parameter int NUM_SLV   = 32,
    parameter int ROM_IDX   = 4,
    parameter int RAM_IDX   = 6,
    parameter int BASE_STEP = 16,
    parameter int DFLT_SIZE = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_wr,
    input  logic                  acc_rd,
    input  logic [11:0]           acc_addr,
    input  logic [3:0]            acc_be,
    input  logic [31:0]           acc_wdata,
    output logic [31:0]           acc_rdata,
    output logic                  acc_err,
    output logic                  remap_active,
    output logic [NUM_SLV*12-1:0] win_base,
    output logic [NUM_SLV*4-1:0]  win_size,
    input  logic [31:0]           bus_addr,
    output logic [NUM_SLV-1:0]    slave_sel
);

    remap_regfile #(
        .NUM_SLV   (NUM_SLV),
        .ROM_IDX   (ROM_IDX),
        .RAM_IDX   (RAM_IDX),
        .BASE_STEP (BASE_STEP),
        .DFLT_SIZE (DFLT_SIZE)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_wr       (acc_wr),
        .acc_rd       (acc_rd),
        .acc_addr     (acc_addr),
        .acc_be       (acc_be),
        .acc_wdata    (acc_wdata),
        .acc_rdata    (acc_rdata),
        .acc_err      (acc_err),
        .remap_active (remap_active),
        .win_base     (win_base),
        .win_size     (win_size)
    );

    remap_decoder #(
        .NUM_SLV (NUM_SLV)
    ) u_dec (
        .win_base  (win_base),
        .win_size  (win_size),
        .bus_addr  (bus_addr),
        .slave_sel (slave_sel)
    );

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slave_sel)); // R9

endmodule

// File: tb/tb_boot_remap_ctrl.sv
module tb_boot_remap_ctrl;

    localparam int N = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acc_wr = 1'b0, acc_rd = 1'b0;
    logic [11:0]     acc_addr = '0;
    logic [3:0]      acc_be = 4'hF;
    logic [31:0]     acc_wdata = '0;
    logic [31:0]     acc_rdata;
    logic            acc_err;
    logic            remap_active;
    logic [N*12-1:0] win_base;
    logic [N*4-1:0]  win_size;
    logic [31:0]     bus_addr = '0;
    logic [N-1:0]    slave_sel;

    int checks = 0, errors = 0;
    logic [31:0] last_rdata;
    logic        last_err;

    boot_remap_ctrl dut (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .acc_addr(acc_addr), .acc_be(acc_be), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_err(acc_err), .remap_active(remap_active),
        .win_base(win_base), .win_size(win_size), .bus_addr(bus_addr),
        .slave_sel(slave_sel)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d,
                          input logic [3:0] be);
        @(negedge clk);
        acc_wr = w; acc_rd = !w; acc_addr = a; acc_wdata = d; acc_be = be;
        @(negedge clk);
        last_rdata = acc_rdata;
        last_err   = acc_err;
        acc_wr = 1'b0; acc_rd = 1'b0; acc_be = 4'hF;
    endtask

    task automatic decode(input string req, input logic [31:0] a, input logic [N-1:0] exp);
        bus_addr = a;
        #1;
        chk(req, slave_sel, exp);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 remap", {31'h0, remap_active}, 32'h0);
        chk("R1 err", {31'h0, acc_err}, 32'h0);
        chk("R1 rdata", acc_rdata, 32'h0);
        chk("R1 base4", {20'h0, win_base[4*12 +: 12]}, 32'h040);
        chk("R1 size4", {28'h0, win_size[4*4 +: 4]}, 32'h1);
        access(1'b0, 12'h07C, 0, 4'hF);
        chk("R1 slot31 word", last_rdata, 32'h1F01_0000);
        access(1'b0, 12'h010, 0, 4'hF);
        chk("R1 R6 slot4 word", last_rdata, 32'h0401_0000);
    endtask

    task automatic t_slot_rw();
        access(1'b1, 12'h00C, 32'h1234_5678, 4'hF);
        chk("R2 write no err", {31'h0, last_err}, 32'h0);
        access(1'b0, 12'h00C, 0, 4'hF);
        chk("R2 readback", last_rdata, 32'h1234_5678);
        access(1'b1, 12'h010, 32'h0401_ABCD, 4'hF);
        access(1'b0, 12'h010, 0, 4'hF);
        chk("R6 low bits masked", last_rdata, 32'h0401_0000);
    endtask

    task automatic t_fixed_regs();
        access(1'b0, 12'h08C, 0, 4'hF);
        chk("R3 revision", last_rdata, 32'h0001_0301);
        access(1'b1, 12'h08C, 32'hFFFF_FFFF, 4'hF);
        access(1'b0, 12'h08C, 0, 4'hF);
        chk("R3 revision after write", last_rdata, 32'h0001_0301);
        access(1'b1, 12'h080, 32'hDEAD_BEEF, 4'hF);
        chk("R3 prio write no err", {31'h0, last_err}, 32'h0);
        access(1'b0, 12'h080, 0, 4'hF);
        chk("R3 prio reads zero", last_rdata, 32'h0);
        access(1'b0, 12'h084, 0, 4'hF);
        chk("R3 idle reads zero", last_rdata, 32'h0);
        chk("R3 idle no err", {31'h0, last_err}, 32'h0);
    endtask

    task automatic t_illegal();
        access(1'b0, 12'h090, 0, 4'hF);
        chk("R8 undefined read data", last_rdata, 32'h0);
        chk("R8 undefined read err", {31'h0, last_err}, 32'h1);
        @(negedge clk);
        chk("R10 err is one cycle", {31'h0, acc_err}, 32'h0);
        access(1'b0, 12'h00E, 0, 4'hF);
        chk("R8 misaligned err", {31'h0, last_err}, 32'h1);
        access(1'b1, 12'h00C, 32'hAAAA_AAAA, 4'h3);
        chk("R8 partial write err", {31'h0, last_err}, 32'h1);
        access(1'b0, 12'h00C, 0, 4'hF);
        chk("R8 partial write no effect", last_rdata, 32'h1234_5678);
        access(1'b1, 12'h088, 32'h1, 4'h1);
        chk("R8 partial ctrl write no remap", {31'h0, remap_active}, 32'h0);
    endtask

    task automatic t_decode();
        decode("R9 slave0", 32'h0000_0000, 32'h1);
        decode("R9 slave5 upper half", 32'h0510_0000, 32'h20);
        decode("R9 no hit", 32'hF000_0000, 32'h0);
        access(1'b1, 12'h008, 32'h0104_0000, 4'hF); // slot 2: base 0x010, 16 MB
        decode("R9 overlap lowest wins", 32'h0100_0000, 32'h2);
        decode("R9 wide window alone", 32'h0180_0000, 32'h4);
        access(1'b1, 12'h004, 32'h0100_0000, 4'hF); // slot 1 size 0
        decode("R9 size zero disabled", 32'h0100_0000, 32'h4);
        access(1'b1, 12'h07C, 32'h000C_0000, 4'hF); // slot 31 match-all
        decode("R9 size 12 matches all", 32'hF000_0000, 32'h8000_0000);
    endtask

    task automatic t_remap();
        access(1'b1, 12'h018, 32'h0603_0000, 4'hF); // RAM slot: 8 MB
        access(1'b1, 12'h088, 32'h1, 4'hF);
        chk("R4 remap on", {31'h0, remap_active}, 32'h1);
        chk("R4 ram base", {20'h0, win_base[6*12 +: 12]}, 32'h040);
        chk("R4 rom base", {20'h0, win_base[4*12 +: 12]}, 32'h048);
        access(1'b0, 12'h010, 0, 4'hF);
        chk("R6 rom readback", last_rdata, 32'h0481_0000);
        access(1'b0, 12'h018, 0, 4'hF);
        chk("R6 ram readback", last_rdata, 32'h0403_0000);
        decode("R4 ram at old rom", 32'h0400_0000, 32'h40);
        decode("R4 rom above ram", 32'h0480_0000, 32'h10);
        access(1'b1, 12'h088, 32'h0, 4'hF);
        chk("R5 clear err", {31'h0, last_err}, 32'h1);
        chk("R5 still remapped", {31'h0, remap_active}, 32'h1);
        access(1'b0, 12'h088, 0, 4'hF);
        chk("R5 ctrl reads one", last_rdata, 32'h1);
        access(1'b1, 12'h010, 32'h0AA2_0000, 4'hF);
        chk("R7 base kept", {20'h0, win_base[4*12 +: 12]}, 32'h048);
        chk("R7 size updated", {28'h0, win_size[4*4 +: 4]}, 32'h2);
        access(1'b0, 12'h010, 0, 4'hF);
        chk("R7 readback", last_rdata, 32'h0482_0000);
        do_reset();
        chk("R1 reset clears remap", {31'h0, remap_active}, 32'h0);
        chk("R1 reset restores rom base", {20'h0, win_base[4*12 +: 12]}, 32'h040);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_slot_rw();
        t_fixed_regs();
        t_illegal();
        t_decode();
        t_remap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule